// File: doc/BRIEF.md
# MDIO Extended-Register Window Sequencer

This block sits between a management agent and a clause-22 MDIO frame engine. It lets the agent reach extended-device (MMD) registers without native clause-45 frames. The agent makes one request that holds a PHY address, a device address, a 16-bit register address, a direction and write data. The block turns that request into four clause-22 accesses through a pair of window registers.

The window pair is made of two registers. Register 0x0D is the control window. Its bits 15:14 hold a command code and its bits 4:0 hold the device address. Register 0x0E is the address/data window. Command 0 makes the data window take a register address, and command 1 makes it carry register contents.

Each sub-access is sent to the frame engine with a valid/ready handshake. The sub-access is complete when the engine raises its response strobe. After the fourth completion, the block pulses done and shows the value read.

Top module: `mmd_win_seq`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0, done is 0 and rdata is 0.
- R2: An accepted request produces exactly four sub-accesses, with register numbers in this order: 0x0D, 0x0E, 0x0D, 0x0E.
- R3: A control word written to 0x0D carries the command in bits 15:14 and the device address in bits 4:0. Bits 13:5 are zero. The first control write uses command 0 (address mode) and the second uses command 1 (data mode).
- R4: The second sub-access is a write of the request's 16-bit register address to 0x0E.
- R5: The first three sub-accesses are writes. The fourth follows the request direction (cmd_write=1 for a write). It carries the request write data for a write and zero for a read.
- R6: Every sub-access carries the request's PHY address. All request fields are captured at acceptance, so later changes on the request inputs have no effect.
- R7: req_ready is 0 from the cycle after acceptance until the fourth completion. A req_valid raised in that time is ignored.
- R8: While cmd_valid is 1 and cmd_ready is 0, cmd_valid stays 1 and the command fields stay unchanged.
- R9: A sub-access completes only on rsp_valid after its command has been accepted. rsp_valid while idle, or while a command is still waiting for cmd_ready, is ignored.
- R10: done is a one-cycle pulse in the cycle after the fourth completion. For a read, rdata then shows the rsp_rdata returned by that completion. A write leaves rdata unchanged.
- R11: req_ready is 1 in the cycle done is 1, so a new request can be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_dev | input | 5 | Extended device address |
| req_addr | input | 16 | Extended register address |
| req_wdata | input | 16 | Write data |
| cmd_valid | output | 1 | Sub-access command present |
| cmd_ready | input | 1 | Frame engine takes the command |
| cmd_write | output | 1 | Sub-access direction |
| cmd_phy | output | 5 | Sub-access PHY address |
| cmd_reg | output | 5 | Clause-22 register number |
| cmd_wdata | output | 16 | Sub-access write data |
| rsp_valid | input | 1 | Frame engine finished the accepted sub-access |
| rsp_rdata | input | 16 | Data read by that sub-access |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last read |

## Verification
Two functions can fall in the same cycle: the done pulse of one transaction and the acceptance of the next request. The bench provokes this by raising req_valid in the very cycle done is high. It then checks that done is high, that req_ready is high, and that the new transaction's four sub-accesses start at once in the right order.

A second case puts rsp_valid beside a command that is still waiting for cmd_ready, or beside the idle state. In both cases the bench checks that the response is ignored: the command stays pending and done stays low.

// File: rtl/mmd_win_pkg.sv
package mmd_win_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam int unsigned CMD_W      = 2;
    localparam logic [1:0]  CMD_ADDRMD = 2'd0;
    localparam logic [1:0]  CMD_DATAMD = 2'd1;
    localparam int unsigned NUM_STEPS  = 4;

endpackage

// File: rtl/mmd_ctl_pack.sv
module mmd_ctl_pack #(
    parameter int unsigned DEV_W   = 5,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned CMD_LSB = 14
) (
    input  logic [mmd_win_pkg::CMD_W-1:0] cmd,
    input  logic [DEV_W-1:0]              dev,
    output logic [DATA_W-1:0]             word
);
    // Control word: command at the top, device address at the bottom, zeros between.
    always_comb begin
        word                                   = '0;
        word[CMD_LSB +: mmd_win_pkg::CMD_W]    = cmd;
        word[DEV_W-1:0]                        = dev;
    end
endmodule

// File: rtl/mmd_step_mux.sv
module mmd_step_mux #(
    parameter int unsigned    REG_W   = 5,
    parameter int unsigned    DEV_W   = 5,
    parameter int unsigned    DATA_W  = 16,
    parameter int unsigned    CMD_LSB = 14,
    parameter int unsigned    STEP_W  = 2,
    parameter logic [REG_W-1:0] CTL_REG = 5'h0D,
    parameter logic [REG_W-1:0] WIN_REG = 5'h0E
) (
    input  logic [STEP_W-1:0] step,
    input  logic              req_wr,
    input  logic [DEV_W-1:0]  dev,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sub_wr,
    output logic [REG_W-1:0]  sub_reg,
    output logic [DATA_W-1:0] sub_wdata
);
    logic [DATA_W-1:0] ctl_word [2];

    // One packer per command code (address mode, data mode).
    for (genvar g = 0; g < 2; g++) begin : g_ctl
        localparam logic [mmd_win_pkg::CMD_W-1:0] CODE = mmd_win_pkg::CMD_W'(g);
        mmd_ctl_pack #(
            .DEV_W  (DEV_W),
            .DATA_W (DATA_W),
            .CMD_LSB(CMD_LSB)
        ) u_pack (
            .cmd (CODE),
            .dev (dev),
            .word(ctl_word[g])
        );
    end

    always_comb begin
        sub_wr    = 1'b1;
        sub_reg   = CTL_REG;
        sub_wdata = ctl_word[0];
        case (step)
            STEP_W'(0): begin
                sub_reg   = CTL_REG;
                sub_wdata = ctl_word[0];
            end
            STEP_W'(1): begin
                sub_reg   = WIN_REG;
                sub_wdata = addr;
            end
            STEP_W'(2): begin
                sub_reg   = CTL_REG;
                sub_wdata = ctl_word[1];
            end
            default: begin
                sub_reg   = WIN_REG;
                sub_wr    = req_wr;
                sub_wdata = req_wr ? wdata : '0;
            end
        endcase
    end
endmodule

// File: rtl/mmd_win_seq.sv
module mmd_win_seq #(
    parameter int unsigned      PHY_W   = 5,
    parameter int unsigned      DEV_W   = 5,
    parameter int unsigned      REG_W   = 5,
    parameter int unsigned      DATA_W  = 16,
    parameter int unsigned      CMD_LSB = 14,
    parameter logic [REG_W-1:0] CTL_REG = 5'h0D,
    parameter logic [REG_W-1:0] WIN_REG = 5'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [PHY_W-1:0]  cmd_phy,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    import mmd_win_pkg::*;

    localparam int unsigned       STEP_W = $clog2(NUM_STEPS);
    localparam logic [STEP_W-1:0] LAST   = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] step;
        logic              wr;
        logic [PHY_W-1:0]  phy;
        logic [DEV_W-1:0]  dev;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, default: '0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st    = ST_ISSUE;
                    seq_d.step  = '0;
                    seq_d.wr    = req_write;
                    seq_d.phy   = req_phy;
                    seq_d.dev   = req_dev;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    seq_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (seq_q.step == LAST) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        if (!seq_q.wr) begin
                            seq_d.rdata = rsp_rdata;
                        end
                    end else begin
                        seq_d.st   = ST_ISSUE;
                        seq_d.step = seq_q.step + 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    mmd_step_mux #(
        .REG_W  (REG_W),
        .DEV_W  (DEV_W),
        .DATA_W (DATA_W),
        .CMD_LSB(CMD_LSB),
        .STEP_W (STEP_W),
        .CTL_REG(CTL_REG),
        .WIN_REG(WIN_REG)
    ) u_step (
        .step     (seq_q.step),
        .req_wr   (seq_q.wr),
        .dev      (seq_q.dev),
        .addr     (seq_q.addr),
        .wdata    (seq_q.wdata),
        .sub_wr   (cmd_write),
        .sub_reg  (cmd_reg),
        .sub_wdata(cmd_wdata)
    );

    assign req_ready = (seq_q.st == ST_IDLE);
    assign cmd_valid = (seq_q.st == ST_ISSUE);
    assign cmd_phy   = seq_q.phy;
    assign done      = seq_q.done;
    assign rdata     = seq_q.rdata;

    // R7: acceptance closes the request port on the next cycle
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R8: a pending command holds its fields
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_reg)
                                  && $stable(cmd_wdata) && $stable(cmd_write));

    // R10: done lasts exactly one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the request port is open while done is high
    p_ready_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R3: middle bits of a control word are zero
    p_ctl_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_reg == CTL_REG |-> cmd_wdata[CMD_LSB-1:DEV_W] == '0);

    // R6: PHY address constant during a transaction
    p_phy_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready && $past(!req_ready) |-> $stable(cmd_phy));

    // R9: no completion pulse while a command waits for acceptance
    p_no_done_in_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !done);
endmodule

// File: tb/mmd_win_seq_bench.sv
module mmd_win_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] CTL = 5'h0D;
    localparam logic [4:0] WIN = 5'h0E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_dev = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic        cmd_write;
    logic [4:0]  cmd_phy;
    logic [4:0]  cmd_reg;
    logic [15:0] cmd_wdata;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_rdata = '0;
    logic        done;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmd_win_seq u_mmd_win_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_phy(req_phy), .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .done(done), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_cmd(input logic exp_wr, input logic [4:0] exp_reg,
                           input logic [15:0] exp_wd, input logic [4:0] exp_phy, input int s);
        chk(cmd_valid == 1'b1, "R2", "cmd_valid", 32'(cmd_valid), 1);
        chk(cmd_reg == exp_reg, (s == 1 || s == 3) ? "R2" : "R3", "cmd_reg", 32'(cmd_reg), 32'(exp_reg));
        chk(cmd_write == exp_wr, "R5", "cmd_write", 32'(cmd_write), 32'(exp_wr));
        chk(cmd_wdata == exp_wd, (s == 1) ? "R4" : ((s == 3) ? "R5" : "R3"),
            "cmd_wdata", 32'(cmd_wdata), 32'(exp_wd));
        chk(cmd_phy == exp_phy, "R6", "cmd_phy", 32'(cmd_phy), 32'(exp_phy));
    endtask

    // Runs one request from acceptance to the done cycle; starts and ends at a negedge.
    task automatic run_txn(input logic wr, input logic [4:0] phy, input logic [4:0] dev,
                           input logic [15:0] addr, input logic [15:0] wd,
                           input logic [15:0] rd_val, input int rdly, input int sdly,
                           input bit poke);
        logic        e_wr;
        logic [4:0]  e_reg;
        logic [15:0] e_wd;
        req_valid = 1'b1;
        req_write = wr; req_phy = phy; req_dev = dev; req_addr = addr; req_wdata = wd;
        chk(req_ready == 1'b1, "R11", "req_ready at request", 32'(req_ready), 1);
        tick();
        req_valid = 1'b0;
        // R6: scramble the request inputs after acceptance
        req_write = ~wr; req_phy = ~phy; req_dev = ~dev; req_addr = ~addr; req_wdata = ~wd;
        chk(req_ready == 1'b0, "R7", "req_ready busy", 32'(req_ready), 0);
        for (int s = 0; s < 4; s++) begin
            case (s)
                0: begin e_wr = 1'b1; e_reg = CTL; e_wd = {2'b00, 9'b0, dev}; end
                1: begin e_wr = 1'b1; e_reg = WIN; e_wd = addr; end
                2: begin e_wr = 1'b1; e_reg = CTL; e_wd = {2'b01, 9'b0, dev}; end
                default: begin e_wr = wr; e_reg = WIN; e_wd = wr ? wd : 16'h0; end
            endcase
            for (int d = 0; d < rdly; d++) begin
                chk_cmd(e_wr, e_reg, e_wd, phy, s);   // R8 hold
                if (d == 0) begin
                    rsp_valid = 1'b1;                 // R9: ignored while pending
                    rsp_rdata = 16'hDEAD;
                end
                tick();
                rsp_valid = 1'b0;
                chk(done == 1'b0, "R9", "done while pending", 32'(done), 0);
            end
            cmd_ready = 1'b1;
            chk_cmd(e_wr, e_reg, e_wd, phy, s);
            tick();
            cmd_ready = 1'b0;
            chk(cmd_valid == 1'b0, "R9", "cmd_valid while waiting", 32'(cmd_valid), 0);
            if (poke) req_valid = 1'b1;               // R7: ignored while busy
            for (int d = 0; d < sdly; d++) begin
                tick();
                chk(cmd_valid == 1'b0, "R9", "cmd_valid while waiting", 32'(cmd_valid), 0);
                chk(req_ready == 1'b0, "R7", "req_ready busy", 32'(req_ready), 0);
            end
            req_valid = 1'b0;
            rsp_valid = 1'b1;
            rsp_rdata = (s == 3) ? rd_val : (16'h1234 ^ 16'(s));
            tick();
            rsp_valid = 1'b0;
            if (s < 3) begin
                chk(done == 1'b0, "R10", "early done", 32'(done), 0);
            end
        end
        if (!wr) exp_rdata = rd_val;
        chk(done == 1'b1, "R10", "done pulse", 32'(done), 1);
        chk(rdata == exp_rdata, "R10", "rdata", 32'(rdata), 32'(exp_rdata));
        chk(req_ready == 1'b1, "R11", "req_ready with done", 32'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R2", "no fifth sub-access", 32'(cmd_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready reset", 32'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid reset", 32'(cmd_valid), 0);
        chk(done == 1'b0, "R1", "done reset", 32'(done), 0);
        chk(rdata == 16'h0, "R1", "rdata reset", 32'(rdata), 0);
        rst_n = 1'b1;
        tick();
        for (int dv = 0; dv < 32; dv++) begin
            for (int w = 0; w < 2; w++) begin
                logic [4:0]  phy;
                logic [15:0] addr, wd, rv;
                phy  = 5'((dv * 7 + 3 + w) % 32);
                addr = 16'((dv * 16'h0813) ^ (w << 15));
                wd   = 16'hA5C3 ^ 16'(dv << 4);
                rv   = 16'h5A00 | 16'(dv * 5 + w);
                run_txn(w[0], phy, 5'(dv), addr, wd, rv, dv % 3, (dv / 3) % 3, dv[0]);
                if ((dv % 4) != 0) begin
                    // idle gap: stray response must be ignored (R9), done must fall (R10)
                    rsp_valid = 1'b1;
                    rsp_rdata = 16'hBEEF;
                    tick();
                    rsp_valid = 1'b0;
                    chk(done == 1'b0, "R10", "done falls", 32'(done), 0);
                    chk(cmd_valid == 1'b0, "R9", "idle stray rsp", 32'(cmd_valid), 0);
                    chk(rdata == exp_rdata, "R9", "rdata idle", 32'(rdata), 32'(exp_rdata));
                    tick();
                    chk(done == 1'b0, "R9", "no done from stray rsp", 32'(done), 0);
                end
                // dv%4==0: next request is raised in the done cycle (R11)
            end
        end
        tick();
        chk(done == 1'b0, "R10", "final done low", 32'(done), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule